// File: doc/BRIEF.md
# Partition-Enforcing Victim Selector

This block picks the way to evict when a thread misses in a set of a shared set-associative cache. Several threads share the cache, and each has a programmable target for the number of lines it should hold across the whole cache. The block keeps a running count of the lines each thread currently holds. On every miss it uses those counts and targets to pick a victim, so ownership shifts between threads one line at a time and the cache never stops serving accesses while a new split takes effect.

Each miss request carries the requesting thread, the valid bit and owner of every way in the set, and an age rank for every way supplied by the base replacement policy (a larger rank means less recently used). Among the ways that are allowed, the block always takes the one with the largest rank. The response comes back one cycle after the request is accepted, together with a code for the kind of decision. The allocation counters are updated at the same edge.

Top module: `psel_victim_sel`

## Requirements
- R1: After reset there is no response pending, every current-allocation count reads 0, and every target equals the total line count divided by the number of threads.
- R2: A write to a target register takes effect at the next clock edge and is used by every later decision.
- R3: If any way of the set is invalid, the victim is the invalid way with the largest rank. The kind code is 0 (fill) and the requester's count rises by one.
- R4: If the set is full and the requester holds fewer lines than its target, and a way is owned by another thread that holds more than its target, the victim is the largest-ranked such way. The kind code is 1 (steal), the owner's count falls by one and the requester's count rises by one.
- R5: If the set is full, no steal applies, and the requester owns a way in the set, the victim is the requester's largest-ranked way. The kind code is 2 (own) and no count changes.
- R6: If the set is full, no steal applies, and the requester owns no way in the set, the victim is the largest-ranked way overall. The kind code is 3 (forced), the owner's count falls by one and the requester's count rises by one.
- R7: A response becomes valid in the cycle after a request is accepted. While the response is valid and not taken, the victim and kind hold steady and no new request is accepted.
- R8: Counts change only when a request is accepted.
- R9: A target write never lowers request readiness. A write in the same cycle as an accepted request does not affect that request's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_we | input | 1 | Target register write enable |
| tgt_sel | input | TID_W | Thread whose target is written |
| tgt_data | input | CNT_W | New target value in lines |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Request can be accepted |
| req_tid | input | TID_W | Thread that missed |
| req_wvalid | input | NWAYS | Valid bit of each way in the set |
| req_owner | input | NWAYS*TID_W | Owner thread of each way, way 0 in the low bits |
| req_rank | input | NWAYS*WAY_W | Age rank of each way, larger means older |
| rsp_valid | output | 1 | Victim response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_way | output | WAY_W | Chosen victim way |
| rsp_kind | output | 2 | 0 fill, 1 steal, 2 own, 3 forced |
| cur_alloc | output | NTHREADS*CNT_W | Current line count of each thread, thread 0 in the low bits |

## Verification
The assertions assume the requests describe a consistent cache. The ranks of a set must form a permutation, owner fields must name real threads, and the counts must match the lines the cache actually holds, so no count ever goes below zero. The bench keeps these assumptions by keeping its own model of every set. Each request is built from that model with a freshly shuffled rank permutation, and the model takes each returned victim into account before the next miss is sent. Thread, set, response stalls and target writes come from a seeded random source. Directed sequences force a steal, a forced transfer and an own-line choice while the requester is below target.

// File: rtl/psel_pkg.sv
package psel_pkg;
  typedef enum logic [1:0] {
    VK_FILL   = 2'd0,
    VK_STEAL  = 2'd1,
    VK_OWN    = 2'd2,
    VK_FORCED = 2'd3
  } vkind_e;
endpackage

// File: rtl/psel_lru_pick.sv
module psel_lru_pick #(
  parameter int NWAYS = 8,
  parameter int WAY_W = 3
) (
  input  logic [NWAYS-1:0]       mask,
  input  logic [NWAYS*WAY_W-1:0] rank,
  output logic                   found,
  output logic [WAY_W-1:0]       sel
);
  logic [WAY_W-1:0] best_r;

  always_comb begin
    found  = 1'b0;
    sel    = '0;
    best_r = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (mask[w] && (!found || rank[w*WAY_W +: WAY_W] > best_r)) begin
        found  = 1'b1;
        sel    = WAY_W'(w);
        best_r = rank[w*WAY_W +: WAY_W];
      end
    end
  end
endmodule

// File: rtl/psel_alloc_regs.sv
module psel_alloc_regs #(
  parameter int NTHREADS = 4,
  parameter int TID_W    = 2,
  parameter int CNT_W    = 14,
  parameter int TGT_INIT = 2048
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tgt_we,
  input  logic [TID_W-1:0]          tgt_sel,
  input  logic [CNT_W-1:0]          tgt_data,
  input  logic                      inc_en,
  input  logic [TID_W-1:0]          inc_id,
  input  logic                      dec_en,
  input  logic [TID_W-1:0]          dec_id,
  output logic [NTHREADS*CNT_W-1:0] cur_o,
  output logic [NTHREADS*CNT_W-1:0] tgt_o
);
  logic [CNT_W-1:0] cur_q [NTHREADS];
  logic [CNT_W-1:0] cur_d [NTHREADS];
  logic [CNT_W-1:0] tgt_q [NTHREADS];
  logic [CNT_W-1:0] tgt_d [NTHREADS];

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    always_comb begin
      cur_d[t] = cur_q[t];
      if (inc_en && inc_id == TID_W'(t) && !(dec_en && dec_id == TID_W'(t)))
        cur_d[t] = cur_q[t] + 1'b1;
      else if (dec_en && dec_id == TID_W'(t) && !(inc_en && inc_id == TID_W'(t)))
        cur_d[t] = cur_q[t] - 1'b1;
      tgt_d[t] = (tgt_we && tgt_sel == TID_W'(t)) ? tgt_data : tgt_q[t];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q[t] <= '0;
        tgt_q[t] <= CNT_W'(TGT_INIT);
      end else begin
        if (inc_en || dec_en) cur_q[t] <= cur_d[t];
        if (tgt_we)           tgt_q[t] <= tgt_d[t];
      end
    end

    assign cur_o[t*CNT_W +: CNT_W] = cur_q[t];
    assign tgt_o[t*CNT_W +: CNT_W] = tgt_q[t];
  end

  // R8: no update request, no count movement
  a_r8_idle_counts_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !dec_en) |=> $stable(cur_o));

  // R4/R6: a donor always holds at least one line
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> (cur_q[dec_id] != '0));
endmodule

// File: rtl/psel_victim_sel.sv
module psel_victim_sel
  import psel_pkg::*;
#(
  parameter int NWAYS    = 8,
  parameter int NTHREADS = 4,
  parameter int NSETS    = 1024,
  localparam int WAY_W   = (NWAYS > 1) ? $clog2(NWAYS) : 1,
  localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int TOTAL   = NSETS * NWAYS,
  localparam int CNT_W   = $clog2(TOTAL + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tgt_we,
  input  logic [TID_W-1:0]          tgt_sel,
  input  logic [CNT_W-1:0]          tgt_data,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [TID_W-1:0]          req_tid,
  input  logic [NWAYS-1:0]          req_wvalid,
  input  logic [NWAYS*TID_W-1:0]    req_owner,
  input  logic [NWAYS*WAY_W-1:0]    req_rank,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [WAY_W-1:0]          rsp_way,
  output logic [1:0]                rsp_kind,
  output logic [NTHREADS*CNT_W-1:0] cur_alloc
);
  localparam int TGT_INIT = TOTAL / NTHREADS;

  logic [NTHREADS*CNT_W-1:0] tgt_flat;
  logic [CNT_W-1:0] cur_a [NTHREADS];
  logic [CNT_W-1:0] tgt_a [NTHREADS];
  logic [NTHREADS-1:0] over;
  logic [TID_W-1:0] own_a [NWAYS];
  logic [NWAYS-1:0] inv_m, own_m, don_m, pick_m;
  logic under, found;
  logic [WAY_W-1:0] pick_sel;
  vkind_e kind_c;
  logic acc;
  logic inc_en, dec_en;
  logic [TID_W-1:0] dec_id;

  logic rsp_valid_q, rsp_valid_d;
  logic [WAY_W-1:0] rsp_way_q;
  vkind_e rsp_kind_q;

  for (genvar t = 0; t < NTHREADS; t++) begin : g_over
    assign cur_a[t] = cur_alloc[t*CNT_W +: CNT_W];
    assign tgt_a[t] = tgt_flat[t*CNT_W +: CNT_W];
    assign over[t]  = cur_a[t] > tgt_a[t];
  end

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    assign own_a[w] = req_owner[w*TID_W +: TID_W];
    assign inv_m[w] = !req_wvalid[w];
    assign own_m[w] = req_wvalid[w] && own_a[w] == req_tid;
    assign don_m[w] = req_wvalid[w] && own_a[w] != req_tid && over[own_a[w]];
  end

  assign under = cur_a[req_tid] < tgt_a[req_tid];

  always_comb begin
    if (|inv_m) begin
      pick_m = inv_m;  kind_c = VK_FILL;
    end else if (under && |don_m) begin
      pick_m = don_m;  kind_c = VK_STEAL;
    end else if (|own_m) begin
      pick_m = own_m;  kind_c = VK_OWN;
    end else begin
      pick_m = '1;     kind_c = VK_FORCED;
    end
  end

  psel_lru_pick #(.NWAYS(NWAYS), .WAY_W(WAY_W)) u_pick (
    .mask(pick_m), .rank(req_rank), .found(found), .sel(pick_sel)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign inc_en    = acc && kind_c != VK_OWN;
  assign dec_en    = acc && (kind_c == VK_STEAL || kind_c == VK_FORCED);
  assign dec_id    = own_a[pick_sel];

  psel_alloc_regs #(
    .NTHREADS(NTHREADS), .TID_W(TID_W), .CNT_W(CNT_W), .TGT_INIT(TGT_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .tgt_we(tgt_we), .tgt_sel(tgt_sel), .tgt_data(tgt_data),
    .inc_en(inc_en), .inc_id(req_tid), .dec_en(dec_en), .dec_id(dec_id),
    .cur_o(cur_alloc), .tgt_o(tgt_flat)
  );

  always_comb begin
    rsp_valid_d = rsp_valid_q;
    if (acc)            rsp_valid_d = 1'b1;
    else if (rsp_ready) rsp_valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_way_q   <= '0;
      rsp_kind_q  <= VK_FILL;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (acc) begin
        rsp_way_q  <= pick_sel;
        rsp_kind_q <= kind_c;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_way   = rsp_way_q;
  assign rsp_kind  = rsp_kind_q;

  a_r7_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  a_r7_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_way) && $stable(rsp_kind)));

  a_r3_fill_hits_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && |inv_m) |-> (found && !req_wvalid[pick_sel]));

  a_r4_steal_from_over: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && kind_c == VK_STEAL) |-> (over[own_a[pick_sel]] && own_a[pick_sel] != req_tid));

  a_r5_own_way_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && kind_c == VK_OWN) |-> (req_wvalid[pick_sel] && own_a[pick_sel] == req_tid));
endmodule

// File: tb/psel_victim_sel_tb_top.sv
module psel_victim_sel_tb_top;
  localparam int NW = 8, NT = 4, NS = 4;
  localparam int WW = 3, TW = 2, CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tgt_we = 1'b0;
  logic [TW-1:0] tgt_sel = '0;
  logic [CW-1:0] tgt_data = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [TW-1:0] req_tid = '0;
  logic [NW-1:0] req_wvalid = '0;
  logic [NW*TW-1:0] req_owner = '0;
  logic [NW*WW-1:0] req_rank = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [WW-1:0] rsp_way;
  logic [1:0] rsp_kind;
  logic [NT*CW-1:0] cur_alloc;

  always #4 clk = ~clk;

  psel_victim_sel #(.NWAYS(NW), .NTHREADS(NT), .NSETS(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .tgt_we(tgt_we), .tgt_sel(tgt_sel), .tgt_data(tgt_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_tid(req_tid),
    .req_wvalid(req_wvalid), .req_owner(req_owner), .req_rank(req_rank),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_way(rsp_way),
    .rsp_kind(rsp_kind), .cur_alloc(cur_alloc)
  );

  int n_chk = 0, n_fail = 0;
  bit mval [NS][NW];
  int mown [NS][NW];
  int ecur [NT];
  int etgt [NT];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic chk_counts(input string rq);
    for (int t = 0; t < NT; t++)
      chk(int'(cur_alloc[t*CW +: CW]) == ecur[t], rq,
          int'(cur_alloc[t*CW +: CW]), ecur[t]);
  endtask

  task automatic wtgt(input int t, input int v);
    @(negedge clk);
    tgt_we = 1'b1; tgt_sel = TW'(t); tgt_data = CW'(v);
    @(posedge clk);
    etgt[t] = v;
    @(negedge clk);
    tgt_we = 1'b0;
  endtask

  // one miss: model decision, drive, check, update the model
  task automatic send(input int tid, input int s, input bit stall, input bit wr_same,
                      input string rq);
    int rk[NW];
    int ew, ek, best, tmp, j, donor;
    bit any_inv, any_don, any_own, under;
    for (int i = 0; i < NW; i++) rk[i] = i;
    for (int i = NW-1; i > 0; i--) begin
      j = int'($urandom % (i+1)); tmp = rk[i]; rk[i] = rk[j]; rk[j] = tmp;
    end
    any_inv = 0; any_don = 0; any_own = 0;
    under = ecur[tid] < etgt[tid];
    for (int w = 0; w < NW; w++) begin
      if (!mval[s][w]) any_inv = 1;
      else if (mown[s][w] == tid) any_own = 1;
      else if (ecur[mown[s][w]] > etgt[mown[s][w]]) any_don = 1;
    end
    if (any_inv) ek = 0;
    else if (under && any_don) ek = 1;
    else if (any_own) ek = 2;
    else ek = 3;
    ew = 0; best = -1;
    for (int w = 0; w < NW; w++) begin
      bit ok;
      case (ek)
        0: ok = !mval[s][w];
        1: ok = mval[s][w] && mown[s][w] != tid && ecur[mown[s][w]] > etgt[mown[s][w]];
        2: ok = mval[s][w] && mown[s][w] == tid;
        default: ok = 1;
      endcase
      if (ok && rk[w] > best) begin best = rk[w]; ew = w; end
    end
    @(negedge clk);
    req_valid = 1'b1; req_tid = TW'(tid);
    for (int w = 0; w < NW; w++) begin
      req_wvalid[w] = mval[s][w];
      req_owner[w*TW +: TW] = TW'(mown[s][w]);
      req_rank[w*WW +: WW] = WW'(rk[w]);
    end
    rsp_ready = !stall;
    if (wr_same) begin
      tgt_we = 1'b1; tgt_sel = TW'(tid); tgt_data = CW'($urandom % 17);
    end
    #1;
    chk(req_ready == 1'b1, "R9 ready with request", int'(req_ready), 1);
    @(posedge clk);
    if (wr_same) etgt[tid] = int'(tgt_data);
    donor = mown[s][ew];
    if (ek != 2) ecur[tid]++;
    if (ek == 1 || ek == 3) ecur[donor]--;
    mval[s][ew] = 1; mown[s][ew] = tid;
    @(negedge clk);
    req_valid = 1'b0; tgt_we = 1'b0;
    chk(rsp_valid == 1'b1, {"R7 response valid ", rq}, int'(rsp_valid), 1);
    chk(int'(rsp_way) == ew, {"way ", rq}, int'(rsp_way), ew);
    chk(int'(rsp_kind) == ek, {"kind ", rq}, int'(rsp_kind), ek);
    chk_counts({"counts ", rq});
    if (stall) begin
      @(posedge clk); @(negedge clk);
      chk(rsp_valid && int'(rsp_way) == ew && int'(rsp_kind) == ek,
          "R7 hold under stall", int'(rsp_way), ew);
      chk(req_ready == 1'b0, "R7 no accept under stall", int'(req_ready), 0);
      chk_counts("R8 counts still during stall");
      rsp_ready = 1'b1;
    end
    @(posedge clk); @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 response retired", int'(rsp_valid), 0);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s0;
    s0 = int'($urandom(32'd20240611));
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin mval[s][w] = 0; mown[s][w] = 0; end
    for (int t = 0; t < NT; t++) begin ecur[t] = 0; etgt[t] = NS*NW/NT; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);
    chk_counts("R1 counts zero after reset");

    // R3: set 0 filled entirely by thread 1
    for (int i = 0; i < NW; i++) send(1, 0, 0, 0, "R3 fill");
    // R6: targets equal counts, thread 0 owns nothing in set 0
    for (int t = 0; t < NT; t++) wtgt(t, ecur[t]);
    send(0, 0, 0, 0, "R6 forced");
    // R2/R4: raise thread 0, lower thread 1, then thread 0 steals
    wtgt(0, ecur[0] + 5);
    wtgt(1, ecur[1] - 4);
    send(0, 0, 1, 0, "R4 steal");
    // R5: thread 1 over target takes its own line
    send(1, 0, 0, 0, "R5 own over target");
    // R5: thread 0 under target but no donor in set
    wtgt(1, ecur[1]);
    send(0, 0, 0, 0, "R5 own under target");
    // R8: counts hold while idle
    repeat (3) @(negedge clk);
    chk_counts("R8 idle counts");

    // constrained random mix
    for (int n = 0; n < 800; n++) begin
      if ($urandom % 8 == 0) wtgt(int'($urandom % NT), int'($urandom % 17));
      send(int'($urandom % NT), int'($urandom % NS), ($urandom % 4) == 0,
           ($urandom % 10) == 0, "R2 R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule